// File: doc/BRIEF.md
# Parallel Integer Square Root

This block returns the integer square root of an unsigned radicand word with no iteration over time. The radicand of `RAD_W` bits (even) is split into `RAD_W/2` two-bit groups. A chain of identical stages takes these groups from the most significant group downward. Each stage produces one bit of the root, most significant bit first.

Each stage shifts the running remainder left by two places and appends its bit pair. It then compares the result against a trial value: the root found so far, followed by binary `01`. If the trial fits, the stage subtracts it and the root bit is 1. Otherwise the stage passes the shifted remainder on untouched and the root bit is 0. No value is ever added back.

The last stage only needs the comparison, so it is built as a reduced variant. The result leaves through an output register when `OUT_REG` is 1, or straight from the array when it is 0.

Top module: `isqrt_array`

## Requirements
- R1: For every radicand D, the root output equals floor(sqrt(D)), taken as an unsigned `RAD_W/2`-bit value.
- R2: A radicand of 169 (binary 10101001, `RAD_W` = 8) gives a root of 13 (binary 1101).
- R3: A radicand of 0 gives a root of 0.
- R4: An all-ones radicand gives an all-ones root, that is 2^(RAD_W/2)-1.
- R5: At each perfect square k*k the root is k, and at k*k-1 (k at least 1) the root is k-1.
- R6: With `OUT_REG` = 1, the root for a radicand appears after the first rising clock edge at which that radicand is present. Between edges the root keeps the value captured at the last edge.
- R7: While `rst_n` is low (active low, asynchronous), the registered root reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| radicand | input | RAD_W | Unsigned value whose root is taken |
| root | output | RAD_W/2 | Integer square root, registered when OUT_REG is 1 |

## Verification
The bench sweeps all 256 radicands of the 8-bit build and compares each against a root it finds by search. This covers every point where the root steps up. At k*k and k*k-1 a stage that gets the trial-value comparison wrong by one (strict instead of non-strict, or a wrong `01` suffix) is exposed: it returns k-1 at a perfect square or k just below one. The all-ones radicand drives the remainder to its widest. An array that drops remainder bits returns a root that is too small there. The bench also looks at the output just before and just after a clock edge. An unregistered output, or one delayed by an extra cycle, shows the wrong root at one of those two points.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
   // Width of the root for a given radicand width.
   function automatic int root_width(input int rad_w);
      return rad_w / 2;
   endfunction
endpackage

// File: rtl/isqrt_stage.sv
// One full stage: shift-in a bit pair, test the trial value, keep or subtract.
module isqrt_stage #(
   parameter int ROOT_W = 4
) (
   input  logic [ROOT_W-1:0] rem_in,
   input  logic [ROOT_W-1:0] root_in,
   input  logic [1:0]        pair,
   output logic [ROOT_W-1:0] rem_out,
   output logic [ROOT_W-1:0] root_out
);
   localparam int WORK_W = ROOT_W + 2;

   logic [WORK_W-1:0] shifted;
   logic [WORK_W-1:0] trial;
   logic              fits;

   always_comb begin
      shifted  = {rem_in, pair};
      trial    = {root_in, 2'b01};
      fits     = !(shifted < trial);
      // the true difference fits in ROOT_W bits, so low-bit subtraction is exact
      rem_out  = fits ? (shifted[ROOT_W-1:0] - trial[ROOT_W-1:0])
                      : shifted[ROOT_W-1:0];
      root_out = {root_in[ROOT_W-2:0], fits};
   end
endmodule

// File: rtl/isqrt_tail.sv
// Final stage: only the root bit is needed, so no remainder is formed.
module isqrt_tail #(
   parameter int ROOT_W = 4
) (
   input  logic [ROOT_W-1:0] rem_in,
   input  logic [ROOT_W-1:0] root_in,
   input  logic [1:0]        pair,
   output logic [ROOT_W-1:0] root_out
);
   logic fits;

   always_comb begin
      fits     = !({rem_in, pair} < {root_in, 2'b01});
      root_out = {root_in[ROOT_W-2:0], fits};
   end
endmodule

// File: rtl/isqrt_core.sv
// Combinational chain of ROOT_W stages, most significant pair first.
module isqrt_core #(
   parameter int RAD_W = 8
) (
   input  logic [RAD_W-1:0]                       radicand,
   output logic [isqrt_pkg::root_width(RAD_W)-1:0] root
);
   localparam int ROOT_W = isqrt_pkg::root_width(RAD_W);
   localparam int NSTAGE = ROOT_W;

   logic [ROOT_W-1:0] rem_chain  [NSTAGE];
   logic [ROOT_W-1:0] root_chain [NSTAGE];

   assign rem_chain[0]  = '0;
   assign root_chain[0] = '0;

   for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
      localparam int HI = RAD_W - 1 - 2 * g;
      if (g < NSTAGE - 1) begin : g_full
         isqrt_stage #(.ROOT_W(ROOT_W)) i_stage (
            .rem_in  (rem_chain[g]),
            .root_in (root_chain[g]),
            .pair    (radicand[HI -: 2]),
            .rem_out (rem_chain[g+1]),
            .root_out(root_chain[g+1])
         );
      end else begin : g_last
         isqrt_tail #(.ROOT_W(ROOT_W)) i_tail (
            .rem_in  (rem_chain[g]),
            .root_in (root_chain[g]),
            .pair    (radicand[HI -: 2]),
            .root_out(root)
         );
      end
   end
endmodule

// File: rtl/isqrt_array.sv
module isqrt_array #(
   parameter int RAD_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [RAD_W-1:0]                        radicand,
   output logic [isqrt_pkg::root_width(RAD_W)-1:0] root
);
   localparam int ROOT_W = isqrt_pkg::root_width(RAD_W);

   if (RAD_W % 2 != 0) begin : g_bad_odd
      $error("isqrt_array: RAD_W must be even, got %0d", RAD_W);
   end
   if (RAD_W < 4) begin : g_bad_small
      $error("isqrt_array: RAD_W must be at least 4, got %0d", RAD_W);
   end

   logic [ROOT_W-1:0] root_comb;

   isqrt_core #(.RAD_W(RAD_W)) i_core (
      .radicand(radicand),
      .root    (root_comb)
   );

   if (OUT_REG) begin : g_reg
      logic [ROOT_W-1:0] root_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) root_q <= '0;
         else        root_q <= root_comb;
      end
      assign root = root_q;
   end else begin : g_comb
      assign root = root_comb;
   end
endmodule

// File: rtl/isqrt_array_chk.sv
module isqrt_array_chk #(
   parameter int RAD_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic [RAD_W-1:0]                        radicand,
   input logic [isqrt_pkg::root_width(RAD_W)-1:0] root
);
   localparam int WIDE = RAD_W + 2;

   logic [RAD_W-1:0] rad_d;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rad_d <= '0;
         armed <= 1'b0;
      end else begin
         rad_d <= radicand;
         armed <= 1'b1;
      end
   end

   logic [RAD_W-1:0] seen;
   logic             ok;
   logic [WIDE-1:0]  ext, sq, sq_next;

   always_comb begin
      seen    = OUT_REG ? rad_d : radicand;
      ok      = OUT_REG ? armed : 1'b1;
      ext     = WIDE'(root);
      sq      = ext * ext;
      sq_next = (ext + 1'b1) * (ext + 1'b1);
   end

   // R1
   root_floor_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> sq <= WIDE'(seen));
   // R1
   root_floor_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> sq_next > WIDE'(seen));
   // R3
   zero_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && seen == '0) |-> root == '0);
   // R4
   full_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && seen == '1) |-> root == '1);
endmodule

bind isqrt_array isqrt_array_chk #(.RAD_W(RAD_W), .OUT_REG(OUT_REG)) i_chk (.*);

// File: tb/test_isqrt_array.sv
module test_isqrt_array;
   localparam int CLK_P  = 10;
   localparam int RAD_W  = 8;
   localparam int ROOT_W = RAD_W / 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [RAD_W-1:0]  radicand = '0;
   logic [ROOT_W-1:0] root;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   isqrt_array #(.RAD_W(RAD_W), .OUT_REG(1'b1)) i_isqrt_array (
      .clk(clk), .rst_n(rst_n), .radicand(radicand), .root(root)
   );

   function automatic int ref_root(input int d);
      int r = 0;
      while ((r + 1) * (r + 1) <= d) r++;
      return r;
   endfunction

   task automatic check(input string req, input int got, input int exp, input int d);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s radicand=%0d got=%0d expected=%0d", req, d, got, exp);
      end
   endtask

   // drive at a falling edge, result read at the following falling edge
   task automatic apply(input int d);
      @(negedge clk);
      radicand = RAD_W'(d);
      @(negedge clk);
   endtask

   task automatic t_reset();
      radicand = '1;
      repeat (3) @(negedge clk);
      check("R7", int'(root), 0, int'(radicand));
      rst_n = 1'b1;
   endtask

   task automatic t_named();
      apply(169); check("R2", int'(root), 13, 169);
      apply(0);   check("R3", int'(root), 0, 0);
      apply((1 << RAD_W) - 1);
      check("R4", int'(root), (1 << ROOT_W) - 1, (1 << RAD_W) - 1);
   endtask

   task automatic t_squares();
      for (int k = 1; k < (1 << ROOT_W); k++) begin
         apply(k * k);     check("R5", int'(root), k, k * k);
         apply(k * k - 1); check("R5", int'(root), k - 1, k * k - 1);
      end
   endtask

   task automatic t_latency();
      apply(100);
      check("R6", int'(root), 10, 100);
      @(negedge clk);
      radicand = RAD_W'(49);
      #1 check("R6", int'(root), 10, 49);   // before the edge: old root held
      @(negedge clk);
      check("R6", int'(root), 7, 49);       // after one edge: new root
   endtask

   task automatic t_sweep();
      for (int d = 0; d < (1 << RAD_W); d++) begin
         apply(d);
         check("R1", int'(root), ref_root(d), d);
      end
   endtask

   bit done = 1'b0;

   initial begin
      t_reset();
      t_named();
      t_squares();
      t_latency();
      t_sweep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired got=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end
endmodule